// File: doc/BRIEF.md
# Host Parallel-Port to 68000 Bus Bridge

This block sits between a host that owns only a narrow 16-bit shared parallel bus plus a 3-bit command field and a target bus with 68000-style signalling. For each command, the host writes the address and, for writes, the data as successive phases over the shared bus. The block collects them and then runs one target bus cycle. Address strobe and the data strobes stay high until the target acknowledges. Read results wait in a register. The host collects them over the same shared bus once the busy flag has dropped.

A separate command reads a status word that holds the target's interrupt priority level. An active-low pending flag tells the host that this level has changed since it last read the status word. All target strobes are asserted high. The command code, the address phases and the write data are captured on the rising edge of the host write strobe, sampled in the block clock domain.

Top module: `hbus_bridge`

## Requirements
- R1: The command field uses these codes: 3'b000 word write, 3'b001 word read, 3'b010 byte write, 3'b011 byte read, 3'b100 status read.
- R2: Each write-strobe rise captures one phase in order: address bits 15:0, then address bits 31:16, and for writes the data word. The target address is {phase-two bits [ADDR_W-17:0], phase-one word}. A read cycle starts after the second phase. A write cycle starts only after the third phase.
- R3: The busy output is high from the clock edge that captures the final phase until the edge that samples acknowledge. Address strobe stays high until acknowledge, and it drops on that same edge as busy.
- R4: A word access raises both data strobes. Read/write is high for reads and low for writes. A word write places the data phase on the target data bus. A word read returns the full 16-bit target word.
- R5: A byte write takes the byte from bits 7:0 of the data phase. When A0=0 only the upper strobe is high and the byte sits on bits 15:8. When A0=1 only the lower strobe is high and the byte sits on bits 7:0.
- R6: A byte read returns the target's bits 15:8 when A0=0 and bits 7:0 when A0=1. The byte is zero-extended into bits 7:0 of the result.
- R7: A strobe whose command differs from the last accepted command restarts the sequence at the address-low phase. The unfinished earlier sequence never produces a target cycle.
- R8: If no acknowledge arrives within TMO_CYC clocks (default 256) after address strobe rises, the cycle is dropped and busy falls. For a read, the result is then 16'hFFFF.
- R9: A status read returns the interrupt priority level in bits 15:13, with all other bits zero.
- R10: The pending output is low while the synchronised interrupt level differs from the level returned by the last status read. A status read makes it high again.
- R11: The block drives the shared bus only while the read strobe is high and the command field holds 3'b001, 3'b011 or 3'b100.
- R12: Write strobes that carry code 3'b100 or an unused code (3'b101 to 3'b111) change neither the phase sequence nor the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cmd_i | input | 3 | Host command field |
| hst_wr_i | input | 1 | Host write strobe; rising edge captures a phase |
| hst_rd_i | input | 1 | Host read strobe; enables bus drive |
| hst_bus_io | inout | 16 | Shared address/data bus |
| hst_busy_o | output | 1 | High while a target cycle is pending or running |
| hst_irq_n_o | output | 1 | Low when the interrupt level changed since the last status read |
| tgt_addr_o | output | ADDR_W | Target address |
| tgt_dout_o | output | 16 | Target write data |
| tgt_din_i | input | 16 | Target read data |
| tgt_uds_o | output | 1 | Upper data strobe, high asserted |
| tgt_lds_o | output | 1 | Lower data strobe, high asserted |
| tgt_rw_o | output | 1 | High for read, low for write |
| tgt_as_o | output | 1 | Address strobe, high asserted |
| tgt_ack_i | input | 1 | Target acknowledge |
| tgt_ipl_i | input | 3 | Target interrupt priority level |

## Verification
The assertions assume the host issues no write strobes while busy is high, and that acknowledge arrives only while address strobe is high and lasts a single clock. The bench host tasks always poll busy low before the next command. The bench target model raises acknowledge for exactly one clock after a fixed delay, and stays silent when the timeout is under test. The interrupt level is changed only between host commands, so each level is stable for several clocks before a status read.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   localparam int HB_W = 16;

   typedef enum logic [2:0] {
      CMD_WR16 = 3'b000,
      CMD_RD16 = 3'b001,
      CMD_WR8  = 3'b010,
      CMD_RD8  = 3'b011,
      CMD_STAT = 3'b100
   } hbus_cmd_e;

   function automatic logic cmd_is_xfer(input logic [2:0] c);
      return c[2] == 1'b0;
   endfunction

   function automatic logic cmd_is_read(input logic [2:0] c);
      return (c == CMD_RD16) || (c == CMD_RD8);
   endfunction

   function automatic logic cmd_is_byte(input logic [2:0] c);
      return (c == CMD_WR8) || (c == CMD_RD8);
   endfunction
endpackage

// File: rtl/hbus_phase_cap.sv
module hbus_phase_cap
   import hbus_pkg::*;
#(
   parameter int ADDR_W = 24,
   localparam int HI_W = ADDR_W - 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [2:0]      cmd_i,
   input  logic [HB_W-1:0] bus_i,
   input  logic            hold_i,
   output logic [2:0]      cmd_o,
   output logic [HB_W-1:0] lo_o,
   output logic [HI_W-1:0] hi_o,
   output logic [HB_W-1:0] wd_o,
   output logic            start_o
);
   logic       wr_q;
   logic [1:0] ph_q;
   logic [1:0] ph_cur;
   logic       accept;

   assign accept = wr_i && !wr_q && !hold_i && cmd_is_xfer(cmd_i);
   assign ph_cur = (cmd_i != cmd_o) ? 2'd0 : ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         ph_q    <= 2'd0;
         cmd_o   <= CMD_STAT;
         lo_o    <= '0;
         hi_o    <= '0;
         wd_o    <= '0;
         start_o <= 1'b0;
      end else begin
         wr_q    <= wr_i;
         start_o <= 1'b0;
         if (accept) begin
            cmd_o <= cmd_i;
            case (ph_cur)
               2'd0: begin
                  lo_o <= bus_i;
                  ph_q <= 2'd1;
               end
               2'd1: begin
                  hi_o <= bus_i[HI_W-1:0];
                  if (cmd_is_read(cmd_i)) begin
                     start_o <= 1'b1;
                     ph_q    <= 2'd0;
                  end else begin
                     ph_q <= 2'd2;
                  end
               end
               default: begin
                  wd_o    <= bus_i;
                  start_o <= 1'b1;
                  ph_q    <= 2'd0;
               end
            endcase
         end
      end
   end

   p_single_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
   p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q != 2'd3);
   p_read_no_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == 2'd2) |-> !cmd_is_read(cmd_o));
   p_ignored_codes_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wr_q && !cmd_is_xfer(cmd_i)) |=> $stable(ph_q) && $stable(cmd_o));
endmodule

// File: rtl/hbus_tgt_seq.sv
module hbus_tgt_seq
   import hbus_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int TMO_CYC = 256,
   localparam int HI_W  = ADDR_W - 16,
   localparam int CNT_W = $clog2(TMO_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        cmd_i,
   input  logic [HB_W-1:0]   lo_i,
   input  logic [HI_W-1:0]   hi_i,
   input  logic [HB_W-1:0]   wd_i,
   input  logic              ack_i,
   input  logic [HB_W-1:0]   din_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [HB_W-1:0]   dout_o,
   output logic              as_o,
   output logic              uds_o,
   output logic              lds_o,
   output logic              rw_o,
   output logic              busy_o,
   output logic [HB_W-1:0]   rdata_o
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             byte_q;
   logic             a0_q;
   logic             is_byte;

   assign is_byte = cmd_is_byte(cmd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o  <= '0;
         dout_o  <= '0;
         as_o    <= 1'b0;
         uds_o   <= 1'b0;
         lds_o   <= 1'b0;
         rw_o    <= 1'b1;
         busy_o  <= 1'b0;
         rdata_o <= '0;
         cnt_q   <= '0;
         byte_q  <= 1'b0;
         a0_q    <= 1'b0;
      end else if (start_i) begin
         addr_o <= {hi_i, lo_i};
         rw_o   <= cmd_is_read(cmd_i);
         byte_q <= is_byte;
         a0_q   <= lo_i[0];
         uds_o  <= !is_byte || !lo_i[0];
         lds_o  <= !is_byte || lo_i[0];
         dout_o <= is_byte ? {2{wd_i[7:0]}} : wd_i;
         as_o   <= 1'b1;
         busy_o <= 1'b1;
         cnt_q  <= '0;
      end else if (as_o) begin
         if (ack_i) begin
            if (rw_o) begin
               if (!byte_q)   rdata_o <= din_i;
               else if (a0_q) rdata_o <= {8'h00, din_i[7:0]};
               else           rdata_o <= {8'h00, din_i[15:8]};
            end
            as_o   <= 1'b0;
            uds_o  <= 1'b0;
            lds_o  <= 1'b0;
            busy_o <= 1'b0;
         end else if (cnt_q == CNT_LAST) begin
            if (rw_o) rdata_o <= '1;
            as_o   <= 1'b0;
            uds_o  <= 1'b0;
            lds_o  <= 1'b0;
            busy_o <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   p_release_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (as_o && ack_i && !start_i) |=> !as_o && !busy_o);
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (as_o && !start_i) |=> $stable(addr_o) && $stable(rw_o));
   p_lane_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
      as_o |-> (uds_o || lds_o));
   p_strobe_needs_as_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (uds_o || lds_o) |-> as_o);
endmodule

// File: rtl/hbus_irq_stat.sv
module hbus_irq_stat
   import hbus_pkg::*;
#(
   parameter int IPL_W    = 3,
   parameter int IPL_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IPL_W-1:0] ipl_i,
   input  logic             rd_i,
   input  logic [2:0]       cmd_i,
   output logic [HB_W-1:0]  stat_o,
   output logic             irq_n_o
);
   logic [IPL_W-1:0] ipl_s;
   logic [IPL_W-1:0] seen_q;
   logic             rd_q;
   logic             stat_rd;

   if (IPL_SYNC == 2) begin : g_sync2
      logic [IPL_W-1:0] s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
         end else begin
            s1_q <= ipl_i;
            s2_q <= s1_q;
         end
      end
      assign ipl_s = s2_q;
   end else begin : g_sync1
      logic [IPL_W-1:0] s1_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s1_q <= '0;
         else        s1_q <= ipl_i;
      end
      assign ipl_s = s1_q;
   end

   assign stat_rd = rd_i && !rd_q && (cmd_i == CMD_STAT);
   assign stat_o  = {ipl_s, {(HB_W-IPL_W){1'b0}}};
   assign irq_n_o = (ipl_s == seen_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         seen_q <= '0;
      end else begin
         rd_q <= rd_i;
         if (stat_rd) seen_q <= ipl_s;
      end
   end

   p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && (ipl_s == $past(ipl_s))) |=> (irq_n_o || !$stable(ipl_s)));
   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n_o && !stat_rd) |=> (!irq_n_o || !$stable(ipl_s)));
endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge
   import hbus_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int TMO_CYC  = 256,
   parameter int IPL_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        hst_cmd_i,
   input  logic              hst_wr_i,
   input  logic              hst_rd_i,
   inout  wire  [15:0]       hst_bus_io,
   output logic              hst_busy_o,
   output logic              hst_irq_n_o,
   output logic [ADDR_W-1:0] tgt_addr_o,
   output logic [15:0]       tgt_dout_o,
   input  logic [15:0]       tgt_din_i,
   output logic              tgt_uds_o,
   output logic              tgt_lds_o,
   output logic              tgt_rw_o,
   output logic              tgt_as_o,
   input  logic              tgt_ack_i,
   input  logic [2:0]        tgt_ipl_i
);
   localparam int HI_W = ADDR_W - 16;

   if (ADDR_W < 17 || ADDR_W > 32) begin : g_bad_addr
      $error("hbus_bridge: ADDR_W must lie in 17..32");
   end
   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("hbus_bridge: TMO_CYC must be at least 2");
   end
   if (IPL_SYNC < 1 || IPL_SYNC > 2) begin : g_bad_sync
      $error("hbus_bridge: IPL_SYNC must be 1 or 2");
   end

   logic [2:0]      cmd_q;
   logic [HB_W-1:0] lo_q, wd_q, rdata, stat_word, bus_out;
   logic [HI_W-1:0] hi_q;
   logic            start, eng_busy, bus_oe;

   assign hst_busy_o = start || eng_busy;

   hbus_phase_cap #(.ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .wr_i(hst_wr_i), .cmd_i(hst_cmd_i),
      .bus_i(hst_bus_io), .hold_i(hst_busy_o), .cmd_o(cmd_q),
      .lo_o(lo_q), .hi_o(hi_q), .wd_o(wd_q), .start_o(start)
   );

   hbus_tgt_seq #(.ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd_q),
      .lo_i(lo_q), .hi_i(hi_q), .wd_i(wd_q), .ack_i(tgt_ack_i),
      .din_i(tgt_din_i), .addr_o(tgt_addr_o), .dout_o(tgt_dout_o),
      .as_o(tgt_as_o), .uds_o(tgt_uds_o), .lds_o(tgt_lds_o),
      .rw_o(tgt_rw_o), .busy_o(eng_busy), .rdata_o(rdata)
   );

   hbus_irq_stat #(.IPL_W(3), .IPL_SYNC(IPL_SYNC)) u_irq (
      .clk(clk), .rst_n(rst_n), .ipl_i(tgt_ipl_i), .rd_i(hst_rd_i),
      .cmd_i(hst_cmd_i), .stat_o(stat_word), .irq_n_o(hst_irq_n_o)
   );

   assign bus_oe  = hst_rd_i && (cmd_is_read(hst_cmd_i) || hst_cmd_i == CMD_STAT);
   assign bus_out = (hst_cmd_i == CMD_STAT) ? stat_word : rdata;
   assign hst_bus_io = bus_oe ? bus_out : 16'hzzzz;

   p_as_implies_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_as_o |-> hst_busy_o);
   p_as_rise_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tgt_as_o) |-> $past(hst_busy_o));
endmodule

// File: tb/hbus_bridge_tb_top.sv
module hbus_bridge_tb_top;
   localparam int ADDR_W  = 24;
   localparam int TMO     = 256;
   localparam int ACK_DLY = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] cmd = 3'b100;
   logic wr = 1'b0, rd = 1'b0;
   logic [15:0] drv = '0;
   logic drv_en = 1'b0;
   wire  [15:0] bus_w;
   logic busy, irq_n;
   logic [ADDR_W-1:0] t_addr;
   logic [15:0] t_dout, t_din;
   logic t_uds, t_lds, t_rw, t_as;
   logic ack = 1'b0;
   logic [2:0] ipl = 3'd0;

   int n_chk = 0, n_bad = 0;
   bit resp_en = 1'b1;
   int ack_cnt = 0;
   int n_cyc = 0;
   logic [ADDR_W-1:0] s_addr;
   logic [15:0] s_dout;
   logic s_uds, s_lds, s_rw;

   always #5 clk = ~clk;

   assign bus_w = drv_en ? drv : 16'hzzzz;

   function automatic logic [15:0] mem_val(input logic [ADDR_W-1:0] a);
      return a[15:0] ^ 16'h5A96;
   endfunction
   assign t_din = mem_val(t_addr);

   hbus_bridge #(.ADDR_W(ADDR_W), .TMO_CYC(TMO), .IPL_SYNC(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .hst_cmd_i(cmd), .hst_wr_i(wr),
      .hst_rd_i(rd), .hst_bus_io(bus_w), .hst_busy_o(busy),
      .hst_irq_n_o(irq_n), .tgt_addr_o(t_addr), .tgt_dout_o(t_dout),
      .tgt_din_i(t_din), .tgt_uds_o(t_uds), .tgt_lds_o(t_lds),
      .tgt_rw_o(t_rw), .tgt_as_o(t_as), .tgt_ack_i(ack), .tgt_ipl_i(ipl)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0;
         ack_cnt <= 0;
      end else if (ack) begin
         ack <= 1'b0;
         ack_cnt <= 0;
      end else if (t_as && resp_en) begin
         if (ack_cnt == ACK_DLY) begin
            ack <= 1'b1;
            s_addr <= t_addr;
            s_dout <= t_dout;
            s_uds <= t_uds;
            s_lds <= t_lds;
            s_rw <= t_rw;
            n_cyc <= n_cyc + 1;
         end else begin
            ack_cnt <= ack_cnt + 1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [2:0] c, input logic [15:0] v);
      @(negedge clk);
      cmd = c; drv = v; drv_en = 1'b1; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      @(negedge clk);
      drv_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
   endtask

   task automatic host_read(input logic [2:0] c, output logic [15:0] v);
      @(negedge clk);
      cmd = c; rd = 1'b1;
      #1 v = bus_w;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic do_write(input logic [2:0] c, input logic [23:0] a, input logic [15:0] d);
      strobe(c, a[15:0]);
      strobe(c, {8'h00, a[23:16]});
      strobe(c, d);
      wait_idle();
   endtask

   task automatic do_read(input logic [2:0] c, input logic [23:0] a, output logic [15:0] v);
      strobe(c, a[15:0]);
      strobe(c, {8'h00, a[23:16]});
      wait_idle();
      host_read(c, v);
   endtask

   task automatic t_reset();
      check("R3 reset busy", 32'(busy), 32'd0);
      check("R3 reset as", 32'(t_as), 32'd0);
      check("R10 reset irq_n", 32'(irq_n), 32'd1);
   endtask

   task automatic t_word_write();
      int c0;
      c0 = n_cyc;
      strobe(3'b000, 16'h3456);
      strobe(3'b000, 16'h0012);
      check("R2 no cycle before data phase", 32'(n_cyc - c0), 32'd0);
      check("R2 as low before data phase", 32'(t_as), 32'd0);
      @(negedge clk);
      cmd = 3'b000; drv = 16'hBEEF; drv_en = 1'b1; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      check("R3 busy after final phase", 32'(busy), 32'd1);
      @(negedge clk);
      drv_en = 1'b0;
      check("R3 as held awaiting ack", 32'(t_as), 32'd1);
      wait_idle();
      check("R3 as released", 32'(t_as), 32'd0);
      check("R2 write address", 32'(s_addr), 32'h123456);
      check("R4 write data", 32'(s_dout), 32'hBEEF);
      check("R4 write strobes", {30'd0, s_uds, s_lds}, 32'd3);
      check("R1 write rw low", 32'(s_rw), 32'd0);
   endtask

   task automatic t_word_read();
      logic [15:0] v;
      do_read(3'b001, 24'h002000, v);
      check("R4 word read data", 32'(v), 32'(mem_val(24'h002000)));
      check("R1 read rw high", 32'(s_rw), 32'd1);
      check("R4 read strobes", {30'd0, s_uds, s_lds}, 32'd3);
   endtask

   task automatic t_byte_write();
      do_write(3'b010, 24'h000100, 16'h005A);
      check("R5 even strobes", {30'd0, s_uds, s_lds}, 32'd2);
      check("R5 even lane", 32'(s_dout[15:8]), 32'h5A);
      do_write(3'b010, 24'h000101, 16'h00C7);
      check("R5 odd strobes", {30'd0, s_uds, s_lds}, 32'd1);
      check("R5 odd lane", 32'(s_dout[7:0]), 32'hC7);
   endtask

   task automatic t_byte_read();
      logic [15:0] v;
      logic [15:0] m;
      do_read(3'b011, 24'h000402, v);
      m = mem_val(24'h000402);
      check("R6 even byte", 32'(v), {24'd0, m[15:8]});
      check("R6 even strobes", {30'd0, s_uds, s_lds}, 32'd2);
      do_read(3'b011, 24'h000403, v);
      m = mem_val(24'h000403);
      check("R6 odd byte", 32'(v), {24'd0, m[7:0]});
      check("R6 odd strobes", {30'd0, s_uds, s_lds}, 32'd1);
   endtask

   task automatic t_restart();
      logic [15:0] v;
      int c0;
      c0 = n_cyc;
      strobe(3'b000, 16'h1111);
      strobe(3'b001, 16'h2222);
      strobe(3'b001, 16'h0000);
      wait_idle();
      host_read(3'b001, v);
      check("R7 restart address", 32'(s_addr), 32'h002222);
      check("R7 single cycle", 32'(n_cyc - c0), 32'd1);
      check("R7 restart data", 32'(v), 32'(mem_val(24'h002222)));
   endtask

   task automatic t_ignored();
      strobe(3'b001, 16'h0300);
      strobe(3'b111, 16'hFFFF);
      strobe(3'b100, 16'hFFFF);
      strobe(3'b101, 16'hFFFF);
      strobe(3'b001, 16'h0001);
      wait_idle();
      check("R12 ignored codes keep sequence", 32'(s_addr), 32'h010300);
   endtask

   task automatic t_timeout();
      logic [15:0] v;
      resp_en = 1'b0;
      strobe(3'b001, 16'h0040);
      strobe(3'b001, 16'h0000);
      repeat (200) @(negedge clk);
      check("R8 still busy before timeout", 32'(busy), 32'd1);
      repeat (100) @(negedge clk);
      check("R8 busy dropped after timeout", 32'(busy), 32'd0);
      check("R8 as dropped after timeout", 32'(t_as), 32'd0);
      host_read(3'b001, v);
      check("R8 timeout read value", 32'(v), 32'hFFFF);
      resp_en = 1'b1;
   endtask

   task automatic t_status();
      logic [15:0] v;
      @(negedge clk);
      ipl = 3'd5;
      repeat (4) @(negedge clk);
      check("R10 pending on change", 32'(irq_n), 32'd0);
      host_read(3'b100, v);
      check("R9 status word", 32'(v), 32'hA000);
      @(negedge clk);
      check("R10 cleared by status read", 32'(irq_n), 32'd1);
      ipl = 3'd7;
      repeat (4) @(negedge clk);
      check("R10 pending again", 32'(irq_n), 32'd0);
      host_read(3'b100, v);
      check("R9 status word level 7", 32'(v), 32'hE000);
   endtask

   task automatic t_bus_drive();
      @(negedge clk);
      cmd = 3'b001; rd = 1'b0; drv = 16'h1357; drv_en = 1'b1;
      #1 check("R11 no drive without read strobe", 32'(bus_w), 32'h1357);
      @(negedge clk);
      cmd = 3'b000; rd = 1'b1; drv = 16'h2468;
      #1 check("R11 no drive on write code", 32'(bus_w), 32'h2468);
      @(negedge clk);
      rd = 1'b0; drv_en = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_word_write();
      t_word_read();
      t_byte_write();
      t_byte_read();
      t_restart();
      t_ignored();
      t_timeout();
      t_status();
      t_bus_drive();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule